// File: doc/BRIEF.md
# Keyed Runaway-Detection Watchdog

This block watches for a stalled or runaway program. A binary counter advances once every two clock cycles. A two-bit select input picks one of four counter stages as the detection limit. If software does not service the block before the selected stage is reached, the block raises a one-cycle non-maskable interrupt request and pulls its active-low alarm pin to zero. The counter then starts again from zero, so a program that stays stuck gets a fresh interrupt every interval.

Software services the watchdog by writing one clear key byte to the control write port. That byte zeroes the counter and releases the alarm pin. Stopping the watchdog takes two deliberate steps. The enable input must first be low, and then a separate stop key byte must be written. Any other write value is ignored. When the enable input is driven high again, the watchdog restarts from a zeroed counter.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset the watchdog is running, the interrupt output is 0 and the alarm pin is 1. The first timeout comes one full interval after reset is released.
- R2: The counter advances on every second clock. A timeout fires 2^(TAPk+1) clock edges after the counter was zeroed, where k is the value of tsel_i. Select 0 picks TAP0, the shortest interval, and select 3 picks TAP3.
- R3: A timeout drives nmi_o high for exactly one cycle. In that same cycle the alarm pin wdt_n_o goes to 0.
- R4: After a timeout the counter restarts from zero without any service. The alarm pin stays 0 until the clear key is written, and a further interrupt follows every interval.
- R5: A write of 8'h4E zeroes the counter and the clock phase and sets the alarm pin to 1 from the next cycle. If it lands in the cycle where a timeout would fire, the clear wins and no interrupt is issued.
- R6: A write of any other value has no effect on the count or on the outputs. This includes 8'hB1 while arm_en_i is 1.
- R7: Driving arm_en_i low on its own does not stop the watchdog. A write of 8'hB1 while arm_en_i is 0 stops it, and after that no interrupt is issued.
- R8: While the watchdog is stopped, driving arm_en_i high restarts it from a zeroed counter. The next timeout comes one full interval after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_en_i | input | 1 | Enable bit; must be 0 for the stop key to act |
| tsel_i | input | 2 | Selects one of four counter stages as the interval |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data (key byte) |
| nmi_o | output | 1 | One-cycle non-maskable interrupt request on timeout |
| wdt_n_o | output | 1 | Active-low alarm pin, held low from timeout until cleared |

## Verification
The counter and its half-rate phase cannot be seen directly. A wrong count or a wrong phase therefore shows up only as a change in the interval between the clear and the next interrupt, and that change is visible at the first timeout, at most 2^(TAP3+1) cycles later. The bench measures that interval edge by edge for every select value, with ignored writes injected halfway through each interval. A wrong enable or stop state shows up as an interrupt that appears or goes missing over a long observation window. A wrong pin state shows up at once as the pin failing to hold low, or failing to release in the cycle after the clear key.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned KEY_W     = 8;
    localparam logic [7:0]  KEY_CLEAR = 8'h4E;
    localparam logic [7:0]  KEY_STOP  = 8'hB1;
    localparam int unsigned NUM_TAPS  = 4;

    typedef struct packed {
        logic active;
        logic nmi;
        logic pin_n;
    } wdt_ctl_t;
endpackage

// File: rtl/wdt_key_decode.sv
module wdt_key_decode
    import wdt_pkg::*;
(
    input  logic             wr_en_i,
    input  logic [KEY_W-1:0] wr_data_i,
    input  logic             arm_en_i,
    output logic             clr_hit_o,
    output logic             stop_hit_o
);
    always_comb begin
        clr_hit_o  = wr_en_i && (wr_data_i == KEY_CLEAR);
        // the stop key is honoured only once the enable bit has been dropped
        stop_hit_o = wr_en_i && (wr_data_i == KEY_STOP) && !arm_en_i;
    end
endmodule

// File: rtl/wdt_half_rate.sv
module wdt_half_rate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    logic ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (restart_i) begin
            ph_d = 1'b0;
        end else if (run_i) begin
            ph_d = ~ph_q;
        end
        tick_o = run_i && ph_q && !restart_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ph_q <= 1'b0;
        end else begin
            ph_q <= ph_d;
        end
    end
endmodule

// File: rtl/wdt_tap_counter.sv
module wdt_tap_counter
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 22,
    parameter int unsigned TAP0  = 15,
    parameter int unsigned TAP1  = 17,
    parameter int unsigned TAP2  = 19,
    parameter int unsigned TAP3  = 21
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       restart_i,
    input  logic [1:0] tsel_i,
    output logic       expire_o
);
    localparam int unsigned TAP_IDX [NUM_TAPS] = '{TAP0, TAP1, TAP2, TAP3};

    logic [CNT_W-1:0]    cnt_d, cnt_q;
    logic [CNT_W-1:0]    cnt_nxt;
    logic [NUM_TAPS-1:0] tap_hit;

    assign cnt_nxt = cnt_q + CNT_W'(1);

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign tap_hit[g] = cnt_nxt[TAP_IDX[g]];
    end

    always_comb begin
        expire_o = tick_i && tap_hit[tsel_i];
        cnt_d    = cnt_q;
        if (restart_i || expire_o) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_nxt;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 22,
    parameter int unsigned TAP0  = 15,
    parameter int unsigned TAP1  = 17,
    parameter int unsigned TAP2  = 19,
    parameter int unsigned TAP3  = 21
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             arm_en_i,
    input  logic [1:0]       tsel_i,
    input  logic             wr_en_i,
    input  logic [KEY_W-1:0] wr_data_i,
    output logic             nmi_o,
    output logic             wdt_n_o
);
    wdt_ctl_t ctl_d, ctl_q;
    logic clr_hit, stop_hit, rearm, restart, tick, expire;

    wdt_key_decode u_keys (
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .arm_en_i  (arm_en_i),
        .clr_hit_o (clr_hit),
        .stop_hit_o(stop_hit)
    );

    assign rearm   = !ctl_q.active && arm_en_i;
    assign restart = clr_hit || stop_hit || rearm;

    wdt_half_rate u_phase (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (ctl_q.active),
        .restart_i(restart),
        .tick_o   (tick)
    );

    wdt_tap_counter #(
        .CNT_W(CNT_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)
    ) u_count (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .restart_i(restart),
        .tsel_i   (tsel_i),
        .expire_o (expire)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.nmi = expire;
        if (stop_hit) begin
            ctl_d.active = 1'b0;
        end else if (rearm) begin
            ctl_d.active = 1'b1;
        end
        if (clr_hit) begin
            ctl_d.pin_n = 1'b1;
        end else if (expire) begin
            ctl_d.pin_n = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{active: 1'b1, nmi: 1'b0, pin_n: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign nmi_o   = ctl_q.nmi;
    assign wdt_n_o = ctl_q.pin_n;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       arm_en_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic       nmi_o,
    input logic       wdt_n_o
);
    assert_nmi_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nmi_o |=> !nmi_o);

    assert_nmi_pin_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nmi_o |-> !wdt_n_o);

    assert_pin_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wdt_n_o && !(wr_en_i && wr_data_i == 8'h4E)) |=> !wdt_n_o);

    assert_clear_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_data_i == 8'h4E) |=> (wdt_n_o && !nmi_o));

    assert_rise_by_key_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wdt_n_o) |-> $past(wr_en_i && wr_data_i == 8'h4E));

    assert_stop_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_data_i == 8'hB1 && !arm_en_i) |=> !nmi_o);
endmodule

bind wdt_keyed_top wdt_keyed_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_en_i (arm_en_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .nmi_o    (nmi_o),
    .wdt_n_o  (wdt_n_o)
);

// File: tb/wdt_keyed_tb.sv
`timescale 1ns/1ps
module wdt_keyed_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic [1:0] tsel = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       nmi, pin_n;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // taps 2,3,4,6 give intervals of 8,16,32,128 clocks
    wdt_keyed_top #(.CNT_W(8), .TAP0(2), .TAP1(3), .TAP2(4), .TAP3(6)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .arm_en_i(en), .tsel_i(tsel),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .nmi_o(nmi), .wdt_n_o(pin_n)
    );

    typedef struct packed {
        logic [1:0] sel;
        logic [7:0] junk;
        int         exp_n;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{2'd0, 8'h00, 8},
        '{2'd1, 8'hB1, 16},
        '{2'd2, 8'hFF, 32},
        '{2'd3, 8'h4F, 128},
        '{2'd1, 8'h4D, 16},
        '{2'd3, 8'hE1, 128}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_key();
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h4E;
        @(posedge clk);
        @(negedge clk); wr_en = 1'b0;
    endtask

    // counts clock edges from the current point until nmi is seen high
    task automatic run_to_nmi(input int inject_at, input logic [7:0] junk, output int n);
        n = 0;
        while (!nmi && n < 400) begin
            if (n == inject_at) begin
                wr_en = 1'b1; wr_data = junk;
            end else begin
                wr_en = 1'b0;
            end
            @(posedge clk); n++; @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int hits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(nmi == 1'b0, "R1 nmi at reset", nmi, 0);
        chk(pin_n == 1'b1, "R1 pin at reset", pin_n, 1);
        run_to_nmi(-1, 8'h00, n);
        chk(n == 8, "R1 first interval after reset", n, 8);
        chk(pin_n == 1'b0, "R3 pin low on timeout", pin_n, 0);
        // R4: restart without service
        @(posedge clk); @(negedge clk);
        chk(nmi == 1'b0, "R3 single-cycle pulse", nmi, 0);
        run_to_nmi(-1, 8'h00, n);
        chk(n + 1 == 8, "R4 auto restart interval", n + 1, 8);
        chk(pin_n == 1'b0, "R4 pin held low", pin_n, 0);

        // R2/R6: vector table walk
        foreach (VEC[i]) begin
            tsel = VEC[i].sel;
            clear_key();
            chk(pin_n == 1'b1, "R5 pin released by key", pin_n, 1);
            run_to_nmi(VEC[i].exp_n / 2, VEC[i].junk, n);
            chk(n == VEC[i].exp_n, "R2 R6 interval with ignored write", n, VEC[i].exp_n);
            chk(pin_n == 1'b0, "R3 pin low on timeout", pin_n, 0);
            @(posedge clk); @(negedge clk);
            chk(nmi == 1'b0, "R3 single-cycle pulse", nmi, 0);
            chk(pin_n == 1'b0, "R4 pin stays low", pin_n, 0);
        end

        // R5: clear key colliding with a timeout
        tsel = 2'd1;
        run_to_nmi(-1, 8'h00, n);
        @(posedge clk);
        repeat (14) @(posedge clk);
        @(negedge clk);
        chk(nmi == 1'b0, "R5 before collision", nmi, 0);
        wr_en = 1'b1; wr_data = 8'h4E;
        @(posedge clk); @(negedge clk); wr_en = 1'b0;
        chk(nmi == 1'b0, "R5 clear beats timeout", nmi, 0);
        chk(pin_n == 1'b1, "R5 pin high after clear", pin_n, 1);
        run_to_nmi(-1, 8'h00, n);
        chk(n == 16, "R5 interval restarts at clear", n, 16);

        // R7: enable low alone keeps running, then stop key
        en = 1'b0;
        clear_key();
        run_to_nmi(-1, 8'h00, n);
        chk(n == 16, "R7 enable low alone does not stop", n, 16);
        @(negedge clk); wr_en = 1'b1; wr_data = 8'hB1;
        @(posedge clk); @(negedge clk); wr_en = 1'b0;
        hits = 0;
        for (int k = 0; k < 300; k++) begin
            if (nmi) hits++;
            @(posedge clk); @(negedge clk);
        end
        chk(hits == 0, "R7 no interrupt when stopped", hits, 0);
        chk(pin_n == 1'b0, "R7 pin unchanged by stop", pin_n, 0);
        clear_key();
        chk(pin_n == 1'b1, "R5 clear while stopped", pin_n, 1);

        // R8: re-arm
        tsel = 2'd0;
        en = 1'b1;
        @(posedge clk); @(negedge clk);
        run_to_nmi(-1, 8'h00, n);
        chk(n == 8, "R8 re-armed interval", n, 8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule